// File: doc/BRIEF.md
# AES Inverse Column Mixing Datapath

This block applies the inverse column-mixing step of AES decryption to a full 128-bit state. The state is seen as four columns of four bytes. Each column is multiplied by the inverse circulant matrix over GF(2^8), using the constants 0x0E, 0x0B, 0x0D and 0x09 and the field polynomial x^8+x^4+x^3+x+1.

Every input byte drives one shared multiplier. That multiplier forms its byte shifted left by one, two and three places. The overflow from those shifts is folded back in from the byte's three top bits, once per byte. The four constant products are then taken from two shared partial sums, so no constant repeats an xtime chain of its own.

A parameter selects between a purely combinational path and a registered output. The registered output loads on the cycle the input strobe is high and holds its value otherwise. A decryption round puts this block between the key addition and the inverse row shift.

Top module: `invmix_core`

## Requirements
- R1: State bytes are column-major: column c, row r sits at bits [127-32c-8r -: 8]. A 0x01 byte at bits [127:120] gives column 0 = 0x0E090D0B, and all other columns are zero.
- R2: Output row r of a column is 0E·a[r] ^ 0B·a[r+1] ^ 0D·a[r+2] ^ 09·a[r+3], with indices taken mod 4. For example, column 0x8E4DA1BC maps to 0xDB135345.
- R3: Products are reduced by 0x11B. A lone 0x80 byte in row 0 of column 0 yields column 0 = 0x41ECDAF7.
- R4: Applying the forward column mixing (02,03,01,01 circulant) and then this block returns the original state, for any state.
- R5: Each output column depends only on the input column in the same position.
- R6: A column whose four bytes are equal maps to itself.
- R7: With the output register enabled (default), out_state and out_valid show the result for a state presented with in_valid high on the following clock cycle. out_valid is low on a cycle whose preceding edge saw in_valid low.
- R8: While in_valid is low, the registered out_state keeps its value whatever in_state carries.
- R9: An active-low rst_n clears out_state to zero and out_valid to 0, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input state is present; load enable of the output register |
| in_state | input | 128 | State to transform, column-major |
| out_valid | output | 1 | out_state carries a fresh result |
| out_state | output | 128 | Transformed state |

## Verification
With the default registered output, each result is due one clock edge after its state is sampled. The driver puts inputs on the falling edge and queues the expected state. The monitor takes it off the queue at the next falling edge, which is the first one after the loading edge, and only while out_valid is high. Hold and idle checks look at out_valid and out_state on the falling edges between strobes. A queue left empty at the end shows that no result was lost or duplicated.

// File: rtl/aes_imc_pkg.sv
package aes_imc_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_ROWS  = 4;
  localparam int N_COLS  = 4;
  localparam int COL_W   = BYTE_W * N_ROWS;
  localparam int STATE_W = COL_W * N_COLS;

  typedef logic [BYTE_W-1:0] byte_t;

  // Low byte of the field polynomial x^8+x^4+x^3+x+1
  localparam byte_t FIELD_LOW = 8'h1B;

  typedef struct packed {
    byte_t m9;
    byte_t mb;
    byte_t md;
    byte_t me;
  } imc_prod_t;
endpackage

// File: rtl/gf_imc_mul.sv
module gf_imc_mul
  import aes_imc_pkg::*;
(
  input  byte_t     b,
  output imc_prod_t prod
);
  byte_t fold7, fold6, fold5;
  byte_t sh1, sh2, sh3;
  byte_t sum_lo, sum_hi;

  always_comb begin
    // overflow masks, one per bit that leaves the byte
    fold7 = {BYTE_W{b[7]}} & FIELD_LOW;
    fold6 = {BYTE_W{b[6]}} & FIELD_LOW;
    fold5 = {BYTE_W{b[5]}} & FIELD_LOW;
    // reduced shifts by 1, 2, 3
    sh1 = {b[6:0], 1'b0} ^ fold7;
    sh2 = {b[5:0], 2'b0} ^ {fold7[6:0], 1'b0} ^ fold6;
    sh3 = {b[4:0], 3'b0} ^ {fold7[5:0], 2'b0} ^ {fold6[6:0], 1'b0} ^ fold5;
    // shared partial sums
    sum_lo = sh3 ^ b;
    sum_hi = sh3 ^ sh2;
    prod.m9 = sum_lo;
    prod.mb = sum_lo ^ sh1;
    prod.md = sum_hi ^ b;
    prod.me = sum_hi ^ sh1;
  end
endmodule

// File: rtl/imc_column.sv
module imc_column
  import aes_imc_pkg::*;
(
  input  logic [COL_W-1:0] col_in,
  output logic [COL_W-1:0] col_out
);
  imc_prod_t prod [N_ROWS];

  for (genvar r = 0; r < N_ROWS; r++) begin : g_mul
    gf_imc_mul u_mul (
      .b    (col_in[COL_W-1-BYTE_W*r -: BYTE_W]),
      .prod (prod[r])
    );
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    localparam int I1 = (r + 1) % N_ROWS;
    localparam int I2 = (r + 2) % N_ROWS;
    localparam int I3 = (r + 3) % N_ROWS;
    assign col_out[COL_W-1-BYTE_W*r -: BYTE_W] =
      prod[r].me ^ prod[I1].mb ^ prod[I2].md ^ prod[I3].m9;
  end
endmodule

// File: rtl/invmix_core.sv
module invmix_core
  import aes_imc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [STATE_W-1:0] in_state,
  output logic               out_valid,
  output logic [STATE_W-1:0] out_state
);
  logic [STATE_W-1:0] mixed;

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    imc_column u_col (
      .col_in  (in_state[STATE_W-1-COL_W*c -: COL_W]),
      .col_out (mixed[STATE_W-1-COL_W*c -: COL_W])
    );
  end

  if (REG_OUT) begin : g_reg
    logic [STATE_W-1:0] state_q, state_d;
    logic               valid_q, valid_d;

    always_comb begin
      state_d = state_q;
      if (in_valid) state_d = mixed;
      valid_d = in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        state_q <= '0;
        valid_q <= 1'b0;
      end else begin
        state_q <= state_d;
        valid_q <= valid_d;
      end
    end

    assign out_state = state_q;
    assign out_valid = valid_q;
  end else begin : g_comb
    assign out_state = mixed;
    assign out_valid = in_valid;
  end
endmodule

// File: rtl/invmix_core_chk.sv
module invmix_core_chk
  import aes_imc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [STATE_W-1:0] in_state,
  input logic               out_valid,
  input logic [STATE_W-1:0] out_state
);
  if (REG_OUT) begin : g_reg_chk
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
    end

    a_r7_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (out_valid == $past(in_valid)));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(in_valid)) |-> $stable(out_state));

    a_r6_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_state == {16{in_state[7:0]}}) |=> (out_state == $past(in_state)));

    a_r2_zero_state: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_state == '0) |=> (out_state == '0));

    always @(posedge clk) begin
      if (!rst_n) begin
        a_r9_reset_clear: assert (out_state == '0 && !out_valid);
      end
    end
  end else begin : g_comb_chk
    always_comb begin
      a_r7_comb_valid: assert (out_valid == in_valid);
    end
  end
endmodule

bind invmix_core invmix_core_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_state  (in_state),
  .out_valid (out_valid),
  .out_state (out_state)
);

// File: tb/invmix_core_bench.sv
module invmix_core_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_state;
  logic         out_valid;
  logic [127:0] out_state;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [127:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  invmix_core u_invmix_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_state(in_state),
    .out_valid(out_valid), .out_state(out_state)
  );

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] b, input logic [7:0] k);
    logic [7:0] acc, p;
    acc = 8'h00;
    p   = b;
    for (int i = 0; i < 8; i++) begin
      if (k[i]) acc ^= p;
      p = xt(p);
    end
    return acc;
  endfunction

  function automatic logic [127:0] mixref(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    logic [7:0] a [4];
    logic [7:0] k [4];
    o = '0;
    if (inv) begin k[0]=8'h0E; k[1]=8'h0B; k[2]=8'h0D; k[3]=8'h09; end
    else     begin k[0]=8'h02; k[1]=8'h03; k[2]=8'h01; k[3]=8'h01; end
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) a[r] = s[127-32*c-8*r -: 8];
      for (int r = 0; r < 4; r++)
        o[127-32*c-8*r -: 8] = gm(a[r],k[0]) ^ gm(a[(r+1)%4],k[1]) ^
                               gm(a[(r+2)%4],k[2]) ^ gm(a[(r+3)%4],k[3]);
    end
    return o;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] s, input logic [127:0] exp, input string tag);
    in_valid = 1'b1;
    in_state = s;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: scoreboard pop on each valid result
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected out_valid", out_state, '0);
        end else begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_state == e, t, out_state, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] s, held;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_state = '0;
    repeat (3) @(negedge clk);
    check(out_state == '0, "R9 reset state", out_state, '0);
    check(out_valid == 1'b0, "R9 reset valid", {127'b0, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 known columns
    send({32'h8E4DA1BC, 32'h9FDC589D, 32'hD5D5D7D6, 32'h4D7EBDF8},
         {32'hDB135345, 32'hF20A225C, 32'hD4D4D4D5, 32'h2D26314C}, "R2 known vector");
    // R3 reduction
    send({32'h80000000, 96'h0}, {32'h41ECDAF7, 96'h0}, "R3 0x80 reduction");
    s = {32'hE0FFA0C3, 32'h80E0F0FF, 32'hFFFFFFFE, 32'hC1E1A181};
    send(s, mixref(s, 1'b1), "R3 high-bit bytes");
    // R1 byte placement
    send({8'h01, 120'h0}, {32'h0E090D0B, 96'h0}, "R1 byte at top");
    for (int k = 0; k < 16; k++) begin
      s = 128'h0;
      s[127-8*k -: 8] = 8'h01 + 8'(k);
      send(s, mixref(s, 1'b1), "R1 single byte position");
    end
    // R5 column independence
    s = {32'h11223344, 32'h55667788, 32'h99AABBCC, 32'hDDEEFF00};
    send(s, mixref(s, 1'b1), "R5 base");
    s[63:32] = 32'h0BADF00D;
    send(s, mixref(s, 1'b1), "R5 column 2 changed");
    // R6 uniform columns
    s = {32'hAAAAAAAA, 32'h00000000, 32'hFFFFFFFF, 32'h5C5C5C5C};
    send(s, s, "R6 uniform columns");
    // R4 round trip
    for (int n = 0; n < 24; n++) begin
      s = {$urandom(), $urandom(), $urandom(), $urandom()};
      send(mixref(s, 1'b0), s, "R4 round trip");
    end
    // R7 one-cycle strobe
    in_valid = 1'b0;
    in_state = 128'hDEADBEEF_00000000_12345678_9ABCDEF0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 idle after burst", {127'b0, out_valid}, '0);
    check(exp_q.size() == 0, "R7 queue drained", 128'(exp_q.size()), '0);
    s = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    send(s, mixref(s, 1'b1), "R7 single strobe");
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 valid drops", {127'b0, out_valid}, '0);
    // R8 hold
    held = out_state;
    for (int n = 0; n < 3; n++) begin
      in_state = {$urandom(), $urandom(), $urandom(), $urandom()};
      @(negedge clk);
      check(out_state == held, "R8 hold while idle", out_state, held);
    end
    // R9 async reset mid-run
    rst_n = 1'b0;
    #1;
    check(out_state == '0, "R9 async clear", out_state, '0);
    check(out_valid == 1'b0, "R9 async valid clear", {127'b0, out_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(exp_q.size() == 0, "R7 no result lost", 128'(exp_q.size()), '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule